// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. Twelve sources each raise a set pulse. The block latches the pulse into a pending flag. It then gates the flag by a per-source enable and a global enable, and resolves the winner over two priority levels. The core receives a request level, a 16-bit vector address and a one-cycle vector-taken strobe.

Software reaches the enable, priority and pending state through a small register port with four selects. The core drives two pulses. One marks the end of each instruction and the other marks the completion of a return-from-interrupt. Vectors are only taken at an instruction boundary. The controller keeps one in-service bit per level to decide which requests may nest. A parameter mask picks which sources lose their pending flag in hardware when their vector is taken.

Top module: `intc_top`

## Requirements
- R1: A high bit of `src_evt_i` sets the matching pending flag at the next clock edge, whatever the enables are. Pending flags read back on select 3, with source k at bit k.
- R2: A write to select 3 replaces all pending flags with `reg_wdata_i[11:0]`. A source event in the same cycle still leaves its flag set.
- R3: A source can request only when its enable bit (select 1, bit k) and the global enable are both 1. The global enable is select 0, bit 7. With the global enable at 0, `irq_req_o` stays low whatever the per-source enables are.
- R4: The gated request is registered. `irq_req_o` rises in the cycle after the clock edge at which the last pending or enable condition became true.
- R5: `vec_take_o` is high only in a cycle where `insn_done_i` is high and an eligible request exists.
- R6: `vec_addr_o` equals 0x0003 + 8 × index of the winning source.
- R7: A high-priority candidate (select 2, bit k = 1) beats any low one. Within one level, the lowest source index wins.
- R8: A high-priority request preempts a running low-priority handler. No request is eligible while a high handler runs, and a low request is not eligible while a low handler runs.
- R9: Taking a vector clears the winner's pending flag only if its bit in the auto-clear mask is set (default mask 0x055: sources 0, 2, 4, 6). Other flags stay set.
- R10: A `reti_i` pulse clears the high in-service bit if it is set, and otherwise the low one.
- R11: After `reti_i`, a request still raises `irq_req_o` at once. The next instruction boundary takes no vector, and the boundary after it may.
- R12: A write that clears an enable still lets a vector be taken at a boundary in the very next cycle. It blocks boundaries from the cycle after that onward.
- R13: Reset clears the global enable, the per-source enables, priorities, pending flags, in-service bits and the post-return hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_evt_i | input | 12 | Per-source set pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 enables, 2 priorities, 3 pending |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for the selected register |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| reti_i | input | 1 | Return-from-interrupt completes this cycle |
| irq_req_o | output | 1 | An eligible request exists |
| vec_take_o | output | 1 | Vector taken at this boundary |
| vec_addr_o | output | 16 | Handler address of the winning source |

## Verification
The bench targets the one-cycle window after an enable is cleared. A design that samples the enables live would refuse the single-cycle case, and one that never re-registers them would take the multi-cycle case. It runs the post-return hold, where a missing hold re-enters the handler without running an instruction, and an over-long hold starves the pending source. It checks nesting, where a wrong in-service update lets equal priority preempt or swallows a high request. It also covers auto-clear against non-auto sources and an event racing a software clear of the pending flags. Stretches of seeded random traffic are compared cycle by cycle against a bench reference model.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int VEC_W = 16;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_EN   = 2'd1,
    REG_PRIO = 2'd2,
    REG_PEND = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } isr_t;

  function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] idx,
                                               input logic [VEC_W-1:0] base,
                                               input logic [VEC_W-1:0] stride);
    return base + stride * idx;
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N = 12,
  parameter int DW = 16,
  parameter int GE_BIT = 7,
  parameter int IW = $clog2(N),
  parameter logic [N-1:0] AUTO_CLR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  reg_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [N-1:0]  evt_i,
  input  logic          take_i,
  input  logic [IW-1:0] take_idx_i,
  output logic [N-1:0]  prio_o,
  output logic [N-1:0]  req_o
);
  logic         ge_q;
  logic [N-1:0] en_q, prio_q, pend_q, pend_d, req_q;

  always_comb begin
    pend_d = pend_q;
    if (we_i && sel_i == REG_PEND) pend_d = wdata_i[N-1:0];
    if (take_i && AUTO_CLR[take_idx_i]) pend_d[take_idx_i] = 1'b0;
    pend_d = pend_d | evt_i;  // new events win over clears
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ge_q   <= 1'b0;
      en_q   <= '0;
      prio_q <= '0;
      pend_q <= '0;
      req_q  <= '0;
    end else begin
      if (we_i && sel_i == REG_CTRL) ge_q <= wdata_i[GE_BIT];
      if (we_i && sel_i == REG_EN)   en_q <= wdata_i[N-1:0];
      if (we_i && sel_i == REG_PRIO) prio_q <= wdata_i[N-1:0];
      pend_q <= pend_d;
      // registered gate: an enable clear lags one cycle
      req_q  <= pend_q & en_q & {N{ge_q}};
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      REG_CTRL: rdata_o[GE_BIT] = ge_q;
      REG_EN:   rdata_o[N-1:0] = en_q;
      REG_PRIO: rdata_o[N-1:0] = prio_q;
      REG_PEND: rdata_o[N-1:0] = pend_q;
      default:  rdata_o = '0;
    endcase
  end

  assign prio_o = prio_q;
  assign req_o  = req_q;

  a_r1_evt_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  a_r9_auto_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && AUTO_CLR[take_idx_i] && !evt_i[take_idx_i] && !(we_i && sel_i == REG_PEND))
      |=> !pend_q[$past(take_idx_i)]);

  a_r3_global_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q != '0) |-> $past(ge_q));
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int N = 12,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    hit_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/intc_seq.sv
module intc_seq
  import intc_pkg::*;
#(
  parameter int N = 12,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  prio_i,
  input  logic          insn_done_i,
  input  logic          reti_i,
  output logic          irq_o,
  output logic          take_o,
  output logic [IW-1:0] idx_o
);
  localparam int LVLS = 2;

  logic [N-1:0]  cand [LVLS];
  logic [IW-1:0] pidx [LVLS];
  logic [LVLS-1:0] hit;
  logic hi_ok, lo_ok, hold_q;
  isr_t isr_q;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    assign cand[l] = (l == 1) ? (req_i & prio_i) : (req_i & ~prio_i);
    intc_pick #(.N(N), .IW(IW)) u_pick (
      .req_i(cand[l]),
      .hit_o(hit[l]),
      .idx_o(pidx[l])
    );
  end

  assign hi_ok  = hit[1] && !isr_q.hi;
  assign lo_ok  = hit[0] && !isr_q.hi && !isr_q.lo;
  assign irq_o  = hi_ok || lo_ok;
  assign idx_o  = hi_ok ? pidx[1] : pidx[0];
  assign take_o = insn_done_i && irq_o && !hold_q && !reti_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      if (reti_i) begin
        if (isr_q.hi) isr_q.hi <= 1'b0;
        else          isr_q.lo <= 1'b0;
      end else if (take_o) begin
        if (hi_ok) isr_q.hi <= 1'b1;
        else       isr_q.lo <= 1'b1;
      end
      // one instruction must run after a return
      if (reti_i)           hold_q <= 1'b1;
      else if (insn_done_i) hold_q <= 1'b0;
    end
  end

  a_r5_boundary_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> insn_done_i);

  a_r8_lo_not_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(isr_q.lo) |-> !$past(isr_q.hi));

  a_r10_reti_pops_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && isr_q.hi) |=> (!isr_q.hi && (isr_q.lo == $past(isr_q.lo))));

  a_r11_hold_after_reti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> (!insn_done_i || !take_o));
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int N_SRC = 12,
  parameter int DATA_W = 16,
  parameter int GE_BIT = 7,
  parameter logic [N_SRC-1:0] AUTO_CLR = 12'h055,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0003,
  parameter logic [VEC_W-1:0] VEC_STRIDE = 16'h0008
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_evt_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              insn_done_i,
  input  logic              reti_i,
  output logic              irq_req_o,
  output logic              vec_take_o,
  output logic [VEC_W-1:0]  vec_addr_o
);
  localparam int IW = $clog2(N_SRC);

  logic [N_SRC-1:0] prio, req;
  logic [IW-1:0]    win_idx;
  logic             take;

  intc_regs #(
    .N(N_SRC), .DW(DATA_W), .GE_BIT(GE_BIT), .IW(IW), .AUTO_CLR(AUTO_CLR)
  ) u_regs (
    .clk_i(clk_i),
    .rst_ni(rst_ni),
    .we_i(reg_we_i),
    .sel_i(reg_sel_e'(reg_sel_i)),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .evt_i(src_evt_i),
    .take_i(take),
    .take_idx_i(win_idx),
    .prio_o(prio),
    .req_o(req)
  );

  intc_seq #(.N(N_SRC), .IW(IW)) u_seq (
    .clk_i(clk_i),
    .rst_ni(rst_ni),
    .req_i(req),
    .prio_i(prio),
    .insn_done_i(insn_done_i),
    .reti_i(reti_i),
    .irq_o(irq_req_o),
    .take_o(take),
    .idx_o(win_idx)
  );

  assign vec_take_o = take;
  assign vec_addr_o = vec_of(VEC_W'(win_idx), VEC_BASE, VEC_STRIDE);

  a_r6_vec_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_take_o |-> (vec_addr_o[2:0] == VEC_BASE[2:0]));
endmodule

// File: tb/sim_intc_top.sv
`timescale 1ns/1ps
module sim_intc_top;
  localparam logic [11:0] AUTO = 12'h055;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [11:0] evt = '0;
  logic we = 1'b0;
  logic [1:0] sel = '0;
  logic [15:0] wd = '0;
  logic done = 1'b0;
  logic reti = 1'b0;
  logic [15:0] rdata, vaddr;
  logic irq, take;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  logic [11:0] m_pend = '0, m_en = '0, m_prio = '0, m_req = '0;
  logic m_ge = 1'b0, m_ihi = 1'b0, m_ilo = 1'b0, m_hold = 1'b0;
  logic obs_irq, obs_take;
  logic [15:0] obs_addr, obs_rd;

  always #4 clk = ~clk;

  intc_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_evt_i(evt),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .insn_done_i(done), .reti_i(reti),
    .irq_req_o(irq), .vec_take_o(take), .vec_addr_o(vaddr)
  );

  function automatic int lowest(input logic [11:0] v);
    for (int i = 0; i < 12; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [15:0] exp_vec(input int idx);
    return 16'd3 + 16'd8 * 16'(idx);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [11:0] hc, lc, n_pend;
    logic hi_ok, lo_ok, e_irq, e_take;
    int win;
    logic [15:0] e_rd;
    #2;
    hc = m_req & m_prio;
    lc = m_req & ~m_prio;
    hi_ok = (hc != 0) && !m_ihi;
    lo_ok = (lc != 0) && !m_ihi && !m_ilo;
    e_irq = hi_ok || lo_ok;
    win = hi_ok ? lowest(hc) : lowest(lc);
    e_take = done && e_irq && !m_hold && !reti;
    case (sel)
      2'd0: e_rd = {8'h00, m_ge, 7'h00};
      2'd1: e_rd = {4'h0, m_en};
      2'd2: e_rd = {4'h0, m_prio};
      default: e_rd = {4'h0, m_pend};
    endcase
    obs_irq = irq; obs_take = take; obs_addr = vaddr; obs_rd = rdata;
    chk("R8 model irq_req", {15'h0, irq}, {15'h0, e_irq});
    chk("R5 model vec_take", {15'h0, take}, {15'h0, e_take});
    if (e_irq) chk("R6 model vec_addr", vaddr, exp_vec(win));
    chk("R1 model rdata", rdata, e_rd);
    // next state
    n_pend = m_pend;
    if (we && sel == 2'd3) n_pend = wd[11:0];
    if (e_take && AUTO[win]) n_pend[win] = 1'b0;
    n_pend = n_pend | evt;
    m_req = m_pend & m_en & {12{m_ge}};
    m_pend = n_pend;
    if (we && sel == 2'd0) m_ge = wd[7];
    if (we && sel == 2'd1) m_en = wd[11:0];
    if (we && sel == 2'd2) m_prio = wd[11:0];
    if (reti) begin
      if (m_ihi) m_ihi = 1'b0; else m_ilo = 1'b0;
    end else if (e_take) begin
      if (hi_ok) m_ihi = 1'b1; else m_ilo = 1'b1;
    end
    if (reti) m_hold = 1'b1; else if (done) m_hold = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic cyc(input logic w, input logic [1:0] s, input logic [15:0] d,
                     input logic [11:0] e, input logic dn, input logic rt);
    we = w; sel = s; wd = d; evt = e; done = dn; reti = rt;
    tick();
    we = 1'b0; evt = '0; done = 1'b0; reti = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    cyc(1'b1, s, d, '0, 1'b0, 1'b0);
  endtask

  task automatic idle(input logic dn);
    cyc(1'b0, 2'd3, '0, '0, dn, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R13 reset state
    for (int s = 0; s < 4; s++) begin
      cyc(1'b0, 2'(s), '0, '0, 1'b0, 1'b0);
      chk("R13 reset reg", obs_rd, 16'h0000);
      chk("R13 reset irq", {15'h0, obs_irq}, 16'h0);
    end

    // R1 latch while disabled
    cyc(1'b0, 2'd3, '0, 12'h020, 1'b0, 1'b0);
    idle(1'b0);
    chk("R1 pending latched", obs_rd, 16'h0020);
    chk("R3 disabled no irq", {15'h0, obs_irq}, 16'h0);

    // R3 global off, R4 one-cycle lag
    wr(2'd1, 16'h0020);
    idle(1'b0); idle(1'b0);
    chk("R3 global off", {15'h0, obs_irq}, 16'h0);
    wr(2'd0, 16'h0080);
    idle(1'b0);
    chk("R4 not yet", {15'h0, obs_irq}, 16'h0);
    idle(1'b0);
    chk("R4 irq rises", {15'h0, obs_irq}, 16'h1);

    // R5 / R6
    idle(1'b0);
    chk("R5 no boundary", {15'h0, obs_take}, 16'h0);
    idle(1'b1);
    chk("R5 taken", {15'h0, obs_take}, 16'h1);
    chk("R6 vec src5", obs_addr, 16'h002B);
    idle(1'b0);
    chk("R9 non-auto kept", obs_rd, 16'h0020);
    chk("R8 same level blocked", {15'h0, obs_irq}, 16'h0);

    // R8 high preempts low
    wr(2'd2, 16'h0200);
    wr(2'd1, 16'h0220);
    cyc(1'b0, 2'd3, '0, 12'h200, 1'b0, 1'b0);
    idle(1'b0);
    idle(1'b1);
    chk("R8 preempt", {15'h0, obs_take}, 16'h1);
    chk("R8 vec src9", obs_addr, 16'h004B);
    idle(1'b1);
    chk("R8 hi blocks", {15'h0, obs_take}, 16'h0);
    wr(2'd3, 16'h0020);
    idle(1'b0);
    cyc(1'b0, 2'd3, '0, '0, 1'b1, 1'b1);
    idle(1'b0);
    chk("R10 low still active", {15'h0, obs_irq}, 16'h0);
    cyc(1'b0, 2'd3, '0, '0, 1'b1, 1'b1);
    idle(1'b1);
    chk("R11 irq raised", {15'h0, obs_irq}, 16'h1);
    chk("R11 held one insn", {15'h0, obs_take}, 16'h0);
    idle(1'b1);
    chk("R11 re-entered", {15'h0, obs_take}, 16'h1);
    chk("R11 vec src5", obs_addr, 16'h002B);
    wr(2'd3, 16'h0000);
    cyc(1'b0, 2'd3, '0, '0, 1'b1, 1'b1);
    idle(1'b1);

    // R7 arbitration
    wr(2'd1, 16'h0508);
    wr(2'd2, 16'h0400);
    cyc(1'b0, 2'd3, '0, 12'h508, 1'b0, 1'b0);
    idle(1'b0);
    idle(1'b1);
    chk("R7 high wins", obs_addr, 16'h0053);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0108);
    cyc(1'b0, 2'd3, '0, '0, 1'b1, 1'b1);
    idle(1'b1);
    chk("R7 hold", {15'h0, obs_take}, 16'h0);
    idle(1'b1);
    chk("R7 lowest index", obs_addr, 16'h001B);
    chk("R7 taken", {15'h0, obs_take}, 16'h1);
    wr(2'd3, 16'h0000);
    cyc(1'b0, 2'd3, '0, '0, 1'b1, 1'b1);
    idle(1'b1);

    // R9 auto clear
    wr(2'd1, 16'h0010);
    cyc(1'b0, 2'd3, '0, 12'h010, 1'b0, 1'b0);
    idle(1'b0);
    idle(1'b1);
    chk("R9 vec src4", obs_addr, 16'h0023);
    idle(1'b0);
    chk("R9 auto cleared", obs_rd, 16'h0000);
    cyc(1'b0, 2'd3, '0, '0, 1'b1, 1'b1);
    idle(1'b1);

    // R2 write vs event
    cyc(1'b1, 2'd3, 16'h0000, 12'h004, 1'b0, 1'b0);
    idle(1'b0);
    chk("R2 event wins", obs_rd, 16'h0004);
    wr(2'd3, 16'h0800);
    idle(1'b0);
    chk("R2 write replaces", obs_rd, 16'h0800);
    wr(2'd3, 16'h0000);

    // R12 enable clear window
    wr(2'd1, 16'h0002);
    cyc(1'b0, 2'd3, '0, 12'h002, 1'b0, 1'b0);
    idle(1'b0);
    wr(2'd1, 16'h0000);
    idle(1'b1);
    chk("R12 single-cycle taken", {15'h0, obs_take}, 16'h1);
    chk("R12 vec src1", obs_addr, 16'h000B);
    cyc(1'b0, 2'd3, '0, '0, 1'b1, 1'b1);
    idle(1'b1);
    wr(2'd1, 16'h0002);
    idle(1'b0); idle(1'b0);
    wr(2'd1, 16'h0000);
    idle(1'b0);
    idle(1'b1);
    chk("R12 multi-cycle blocked", {15'h0, obs_take}, 16'h0);

    // R3 global clear masks
    wr(2'd1, 16'h0002);
    idle(1'b0); idle(1'b0);
    wr(2'd0, 16'h0000);
    idle(1'b0); idle(1'b0);
    chk("R3 global masks", {15'h0, obs_irq}, 16'h0);

    // random traffic against the model
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      logic w, dn, rt;
      logic [1:0] s;
      logic [15:0] d;
      logic [11:0] e;
      w  = ($urandom % 8) == 0;
      s  = 2'($urandom % 4);
      d  = 16'($urandom);
      if (s == 2'd0 && ($urandom % 4) != 0) d[7] = 1'b1;
      e  = 12'($urandom & $urandom & $urandom);
      dn = ($urandom % 2) == 0;
      rt = ($urandom % 12) == 0;
      cyc(w, s, d, e, dn, rt);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule